// File: doc/BRIEF.md
# Segmented Read/Write Bank Mapper

This block turns one 8-bit bank-select register into two base offsets for a windowed video memory aperture. One offset serves the read path and the other the write path, so a copy between two regions of video memory needs no bank switching between the read and the write. A two-bit mode field in the same register chooses between 64 KB and 128 KB segments. Mode codes that are not defined leave both offsets as they were.

Two override sources gate the mapping. The first is a lock bit taken from an extended CRTC control register. The second is bit 3 of graphics register 6, which is the upper bit of the memory-map field. A bank register write changes the offsets only when both gates are open. A write to graphics register 6 recomputes the offsets from the stored bank value when both gates are open. Otherwise it clears both offsets. When the memory-map field goes from a nonzero value to zero, the aperture mask widens from 64 KB to a linear 128 KB window.

Top module: `vid_bank_mapper`

## Requirements
- R1: A read of the bank register (`bank_rdata`) returns the last value written. A write is stored whatever the gates, the mode or the memory-map field.
- R2: Bank register bits 2:0 hold the write bank number, which drives `wr_base`. Bits 5:3 hold the read bank number, which drives `rd_base`.
- R3: Mode bits 7:6 = 00 select 128 KB segments: base = bank number × 0x20000.
- R4: Mode bits 7:6 = 01 select 64 KB segments: base = bank number × 0x10000.
- R5: Mode bits 7:6 = 10 or 11 leave both bases unchanged. This holds for a bank write and for a graphics register 6 recompute.
- R6: A bank write updates the bases only when `crtc_lock` is 0 and the stored graphics register 6 bit 3 is 0. Otherwise the bases keep their values.
- R7: A graphics register 6 write whose new bit 3 is 0, while `crtc_lock` is 0, recomputes both bases from the stored bank register.
- R8: A graphics register 6 write with new bit 3 = 1, or with `crtc_lock` = 1, forces both bases to zero.
- R9: A graphics register 6 write that changes bits 3:2 from nonzero to 00 sets `ap_mask` to 0x1FFFF. No other event changes `ap_mask`.
- R10: After reset the bank register, both bases and graphics register 6 are zero, and `ap_mask` is 0xFFFF.
- R11: If a bank write and a graphics register 6 write fall in the same cycle, the graphics register 6 rule applies, and it uses the bank value being written.
- R12: All outputs are registered. They take their new values at the clock edge that samples the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr | input | 1 | Bank register write strobe |
| bank_wdata | input | 8 | Bank register write value |
| bank_rdata | output | 8 | Bank register read value |
| gr6_wr | input | 1 | Graphics register 6 write strobe |
| gr6_wdata | input | 8 | Graphics register 6 write value |
| crtc_lock | input | 1 | CRTC extended control bit 7; 1 blocks bank mapping |
| rd_base | output | ADDR_W | Read window base offset |
| wr_base | output | ADDR_W | Write window base offset |
| ap_mask | output | ADDR_W | Aperture address mask |

## Verification
The hardest state to reach is a recompute triggered by graphics register 6 while the stored bank value was written behind a closed gate. The bases then jump to a value that was never visible when the bank value was written. To get there, the stimulus first closes the gate with a graphics register 6 write that sets bit 3. It then writes a new bank value, which must not move the bases. Finally it reopens the gate with a graphics register 6 write that clears bits 3:2. That same write also drives the memory-map transition that widens the aperture mask. A separate case writes both registers in the same cycle, and seeded random traffic compares every output with the bench model on every clock.

// File: rtl/vid_bank_mapper.sv
module vid_bank_mapper #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [7:0]        bank_wdata,
  output logic [7:0]        bank_rdata,
  input  logic              gr6_wr,
  input  logic [7:0]        gr6_wdata,
  input  logic              crtc_lock,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] wr_base,
  output logic [ADDR_W-1:0] ap_mask
);
  localparam int SEG_SMALL = 16;
  localparam int SEG_LARGE = 17;
  localparam logic [ADDR_W-1:0] MASK_RST = ADDR_W'((1 << SEG_SMALL) - 1);
  localparam logic [ADDR_W-1:0] MASK_EXT = ADDR_W'((1 << SEG_LARGE) - 1);

  logic [7:0] bank_q, gr6_q;
  logic [7:0] src;
  logic       calc_ok, open_bank, open_gr6, map_cleared;
  logic [ADDR_W-1:0] wr_num, rd_num, wr_calc, rd_calc;

  assign src         = bank_wr ? bank_wdata : bank_q;
  assign calc_ok     = (src[7] == 1'b0);
  assign wr_num      = ADDR_W'(src[2:0]);
  assign rd_num      = ADDR_W'(src[5:3]);
  assign wr_calc     = src[6] ? (wr_num << SEG_SMALL) : (wr_num << SEG_LARGE);
  assign rd_calc     = src[6] ? (rd_num << SEG_SMALL) : (rd_num << SEG_LARGE);
  assign open_bank   = !crtc_lock && !gr6_q[3];
  assign open_gr6    = !crtc_lock && !gr6_wdata[3];
  assign map_cleared = (gr6_q[3:2] != 2'b00) && (gr6_wdata[3:2] == 2'b00);
  assign bank_rdata  = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q  <= '0;
      gr6_q   <= '0;
      rd_base <= '0;
      wr_base <= '0;
      ap_mask <= MASK_RST;
    end else begin
      if (bank_wr) bank_q <= bank_wdata;
      if (gr6_wr) begin
        gr6_q <= gr6_wdata;
        if (map_cleared) ap_mask <= MASK_EXT;
        if (!open_gr6) begin
          rd_base <= '0;
          wr_base <= '0;
        end else if (calc_ok) begin
          rd_base <= rd_calc;
          wr_base <= wr_calc;
        end
      end else if (bank_wr && open_bank && calc_ok) begin
        rd_base <= rd_calc;
        wr_base <= wr_calc;
      end
    end
  end

  p_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> bank_rdata == $past(bank_wdata));

  p_reserved_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && !gr6_wr && bank_wdata[7]) |=> ($stable(rd_base) && $stable(wr_base)));

  p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && !gr6_wr && (crtc_lock || gr6_q[3])) |=> ($stable(rd_base) && $stable(wr_base)));

  p_force_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gr6_wr && (crtc_lock || gr6_wdata[3])) |=> (rd_base == '0 && wr_base == '0));

  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gr6_wr |=> $stable(ap_mask));

  p_mask_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_mask == MASK_EXT) |=> (ap_mask == MASK_EXT));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_wr && !gr6_wr) |=> ($stable(rd_base) && $stable(wr_base) && $stable(bank_rdata)));
endmodule

// File: tb/vid_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module vid_bank_mapper_tb_top;
  localparam int ADDR_W = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bank_wr = 1'b0, gr6_wr = 1'b0, crtc_lock = 1'b0;
  logic [7:0] bank_wdata = '0, gr6_wdata = '0;
  logic [7:0] bank_rdata;
  logic [ADDR_W-1:0] rd_base, wr_base, ap_mask;

  int n_chk = 0, n_bad = 0;
  int m_bank = 0, m_gr6 = 0, m_rd = 0, m_wr = 0, m_mask = 'hFFFF;
  string cur_req = "R10";
  bit done = 0;
  int seed = 12345;

  always #2.5 clk = ~clk;

  vid_bank_mapper #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata), .gr6_wr(gr6_wr), .gr6_wdata(gr6_wdata),
    .crtc_lock(crtc_lock), .rd_base(rd_base), .wr_base(wr_base), .ap_mask(ap_mask));

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("bank_rdata", int'(bank_rdata), m_bank);
    chk("rd_base", int'(rd_base), m_rd);
    chk("wr_base", int'(wr_base), m_wr);
    chk("ap_mask", int'(ap_mask), m_mask);
  endtask

  function automatic int seg(int num, int mode);
    return (mode == 1) ? num * 65536 : num * 131072;
  endfunction

  task automatic model(bit bw, int bd, bit gw, int gd, bit lk);
    int src;
    int mode;
    src = bw ? bd : m_bank;
    mode = src / 64;
    if (gw) begin
      if (lk || ((gd / 8) % 2 == 1)) begin
        m_rd = 0; m_wr = 0;
      end else if (mode < 2) begin
        m_wr = seg(src % 8, mode); m_rd = seg((src / 8) % 8, mode);
      end
      if (((m_gr6 / 4) % 4 != 0) && ((gd / 4) % 4 == 0)) m_mask = 'h1FFFF;
      m_gr6 = gd;
    end else if (bw && !lk && ((m_gr6 / 8) % 2 == 0) && mode < 2) begin
      m_wr = seg(src % 8, mode); m_rd = seg((src / 8) % 8, mode);
    end
    if (bw) m_bank = bd;
  endtask

  task automatic op(bit bw, int bd, bit gw, int gd, bit lk);
    bank_wr = bw; bank_wdata = bd[7:0]; gr6_wr = gw; gr6_wdata = gd[7:0]; crtc_lock = lk;
    @(posedge clk);
    #1;
    bank_wr = 0; gr6_wr = 0;
    model(bw, bd, gw, gd, lk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R10"; compare();
    cur_req = "R3"; op(1, 'h1D, 0, 0, 0);
    chk("wr_base R2 field", int'(wr_base), 'hA0000);
    chk("rd_base R2 field", int'(rd_base), 'h60000);
    cur_req = "R4"; op(1, 'h7A, 0, 0, 0);
    chk("wr_base 64K", int'(wr_base), 'h20000);
    chk("rd_base 64K", int'(rd_base), 'h70000);
    cur_req = "R5"; op(1, 'hBF, 0, 0, 0); op(1, 'hC9, 0, 0, 0);
    chk("rd_base hold", int'(rd_base), 'h70000);
    cur_req = "R1"; chk("readback", int'(bank_rdata), 'hC9);
    cur_req = "R6"; op(1, 'h0F, 0, 0, 1);
    chk("locked hold", int'(wr_base), 'h20000);
    cur_req = "R12"; op(0, 0, 0, 0, 0);
    cur_req = "R8"; op(0, 0, 1, 'h08, 0);
    chk("zeroed", int'(wr_base), 0);
    cur_req = "R6"; op(1, 'h12, 0, 0, 0);
    chk("gr6 bit3 hold", int'(rd_base), 0);
    chk("mask unchanged", int'(ap_mask), 'hFFFF);
    cur_req = "R7"; op(0, 0, 1, 'h00, 0);
    chk("recompute wr", int'(wr_base), 'h40000);
    cur_req = "R9"; chk("mask widened", int'(ap_mask), 'h1FFFF);
    cur_req = "R7"; op(0, 0, 1, 'h04, 0);
    cur_req = "R8"; op(0, 0, 1, 'h00, 1);
    chk("lock zero", int'(rd_base), 0);
    cur_req = "R11"; op(1, 'h45, 1, 'h01, 0);
    chk("same-cycle wr", int'(wr_base), 'h50000);
    chk("same-cycle rd", int'(rd_base), 0);
    cur_req = "R5"; op(0, 0, 1, 'h00, 0); op(1, 'h80, 1, 'h02, 0);
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 'hFFFFFF;
      op(r[0], (r >> 4) & 'hFF, r[1] & r[2], (r >> 12) & 'h0F, r[3] & r[5]);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule